// File: doc/BRIEF.md
# Nibble-multiplexed bus cycle demultiplexer

This block sits beside a processor whose 4-bit bus is time-shared. Inside a fixed instruction cycle of eight clock phases, the bus first carries a 12-bit address as three nibbles. It then carries an 8-bit opcode as two nibbles. The remaining phases are left to data transfers. The block counts the phases from a sync marker and collects the nibbles into holding registers. It presents the finished address and opcode to memory and decode logic, each with its own one-clock valid strobe, and holds them while the bus is reused.

The sync input is sampled at a rising edge, and the cycle that follows that edge is phase 0. In regular operation sync is asserted during phase 7 of the previous instruction cycle. When no sync arrives, the phase count wraps from 7 back to 0 and cycles keep coming. A sync that lands anywhere else restarts the cycle. Any field still being collected is thrown away, and its strobe does not fire.

Top module: `nibble_bus_demux`

## Requirements
- R1: `phase_o` becomes 0 after any clock edge at which `sync_i` is high. Otherwise it increments by one per clock and wraps from 7 to 0.
- R2: The address nibbles are taken from `bus_i` at the edges closing phase 0 (bits 3:0), phase 1 (bits 7:4) and phase 2 (bits 11:8). `addr_o` takes the assembled value at the edge closing phase 2.
- R3: The opcode nibbles are taken at the edges closing phase 3 (bits 7:4) and phase 4 (bits 3:0). `opcode_o` takes the assembled value at the edge closing phase 4.
- R4: `addr_vld_o` is high for exactly one clock, the clock in which `phase_o` is 3. `op_vld_o` is high for exactly one clock, the clock in which `phase_o` is 5.
- R5: `addr_o` and `opcode_o` change only together with their own strobe. They hold their value through the data phases and through aborted cycles.
- R6: If `sync_i` is high at an edge that closes phase 0 to 6, the partial field is discarded. If that edge closes phase 2, no address strobe follows. If it closes phase 4, no opcode strobe follows. Fields already completed earlier in the cycle stay valid.
- R7: After reset, `phase_o`, `addr_o` and `opcode_o` are 0 and both strobes are low. No strobe fires until the first sync has been seen.
- R8: When phase 7 ends without a sync, the next cycle is captured and strobed exactly like a cycle that began with a sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one bus phase per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Cycle marker; the next clock is phase 0 |
| bus_i | input | 4 | Shared nibble bus |
| addr_o | output | 12 | Latched instruction address |
| addr_vld_o | output | 1 | One-clock strobe: new address on `addr_o` |
| opcode_o | output | 8 | Latched opcode |
| op_vld_o | output | 1 | One-clock strobe: new opcode on `opcode_o` |
| phase_o | output | 3 | Current phase index 0 to 7 |

## Verification
The risky overlap is a restart by sync that falls on the same edge as the last nibble of a field. That edge would otherwise commit the address or opcode. The bench provokes this by raising sync at the edges that close phase 2 and phase 4. It also aborts a cycle at phase 1 for contrast. After each abort it checks that the strobe stays low, that the held field keeps its older value, and that the next clock reads phase 0. A complete cycle then has to be captured normally.

// File: rtl/nbd_pkg.sv
package nbd_pkg;
  localparam int NIB_W     = 4;
  localparam int ADDR_NIBS = 3;
  localparam int OP_NIBS   = 2;
  localparam int N_PHASES  = 8;
  localparam int PH_W      = $clog2(N_PHASES);
  localparam int ADDR_W    = NIB_W * ADDR_NIBS;
  localparam int OP_W      = NIB_W * OP_NIBS;
  localparam int ADDR_PH0  = 0;
  localparam int OP_PH0    = ADDR_PH0 + ADDR_NIBS;
endpackage

// File: rtl/nbd_phase_ctr.sv
module nbd_phase_ctr #(
  parameter int PH_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sync_i,
  output logic [PH_W-1:0] phase_o,
  output logic            cap_en_o
);
  logic [PH_W-1:0] ph_q;
  logic            aligned_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= '0;
      aligned_q <= 1'b0;
    end else if (sync_i) begin
      ph_q      <= '0;
      aligned_q <= 1'b1;
    end else begin
      ph_q      <= ph_q + 1'b1;
    end
  end

  // a sync at this edge restarts the cycle, so nothing in flight may commit
  assign cap_en_o = aligned_q & ~sync_i;
  assign phase_o  = ph_q;

  p_sync_restart_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (phase_o == '0));
  p_phase_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_i |=> (phase_o == PH_W'($past(phase_o) + 1'b1)));
endmodule

// File: rtl/nbd_field_cap.sv
module nbd_field_cap #(
  parameter int W         = 4,
  parameter int N         = 3,
  parameter int FIRST_PH  = 0,
  parameter bit MSB_FIRST = 1'b0,
  parameter int PH_W      = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cap_en_i,
  input  logic [PH_W-1:0] phase_i,
  input  logic [W-1:0]    bus_i,
  output logic [N*W-1:0]  field_o,
  output logic            vld_o
);
  localparam int LAST_PH = FIRST_PH + N - 1;

  logic [N*W-1:0] merged;
  logic           commit;
  logic [N*W-1:0] field_q;
  logic           vld_q;

  for (genvar k = 0; k < N; k++) begin : g_slot
    localparam int POS = MSB_FIRST ? (N - 1 - k) : k;
    logic hit;
    assign hit = cap_en_i && (phase_i == PH_W'(FIRST_PH + k));
    if (k == N - 1) begin : g_last
      // final nibble goes straight into the output register
      assign merged[POS*W +: W] = bus_i;
      assign commit = hit;
    end else begin : g_hold
      logic [W-1:0] nib_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)  nib_q <= '0;
        else if (hit) nib_q <= bus_i;
      end
      assign merged[POS*W +: W] = nib_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= commit;
      if (commit) field_q <= merged;
    end
  end

  assign field_o = field_q;
  assign vld_o   = vld_q;

  p_vld_phase_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (phase_i == PH_W'(LAST_PH + 1)));
  p_vld_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o);
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> $stable(field_o));
  p_vld_enabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> $past(cap_en_i));
endmodule

// File: rtl/nibble_bus_demux.sv
module nibble_bus_demux
  import nbd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic [NIB_W-1:0]  bus_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_vld_o,
  output logic [OP_W-1:0]   opcode_o,
  output logic              op_vld_o,
  output logic [PH_W-1:0]   phase_o
);
  logic [PH_W-1:0] phase;
  logic            cap_en;

  nbd_phase_ctr #(.PH_W(PH_W)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sync_i   (sync_i),
    .phase_o  (phase),
    .cap_en_o (cap_en)
  );

  nbd_field_cap #(
    .W(NIB_W), .N(ADDR_NIBS), .FIRST_PH(ADDR_PH0), .MSB_FIRST(1'b0), .PH_W(PH_W)
  ) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_en_i (cap_en),
    .phase_i  (phase),
    .bus_i    (bus_i),
    .field_o  (addr_o),
    .vld_o    (addr_vld_o)
  );

  nbd_field_cap #(
    .W(NIB_W), .N(OP_NIBS), .FIRST_PH(OP_PH0), .MSB_FIRST(1'b1), .PH_W(PH_W)
  ) u_op (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_en_i (cap_en),
    .phase_i  (phase),
    .bus_i    (bus_i),
    .field_o  (opcode_o),
    .vld_o    (op_vld_o)
  );

  assign phase_o = phase;

  p_strobes_apart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(addr_vld_o && op_vld_o));
endmodule

// File: tb/nibble_bus_demux_test.sv
module nibble_bus_demux_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sync_i = 1'b0;
  logic [3:0]  bus_i = 4'h0;
  logic [11:0] addr_o;
  logic        addr_vld_o;
  logic [7:0]  opcode_o;
  logic        op_vld_o;
  logic [2:0]  phase_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [11:0] exp_addr = '0;
  logic [7:0]  exp_op = '0;

  always #5 clk = ~clk;

  nibble_bus_demux uut (
    .clk_i(clk), .rst_ni(rst_ni), .sync_i(sync_i), .bus_i(bus_i),
    .addr_o(addr_o), .addr_vld_o(addr_vld_o), .opcode_o(opcode_o),
    .op_vld_o(op_vld_o), .phase_o(phase_o)
  );

  // {sync at end of phase 7, address, opcode}
  localparam logic [20:0] VEC [6] = '{
    21'h1_123_45, 21'h0_FFF_FF, 21'h1_000_00,
    21'h1_800_01, 21'h0_A5C_3E, 21'h1_5A3_C7
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // drives phases 0..stop; sync raised at phase 'stop' when sync_last set
  task automatic run_cyc(input logic [11:0] a, input logic [7:0] op,
                         input int stop, input bit sync_last);
    for (int i = 0; i <= stop; i++) begin
      bit s;
      s = sync_last && (i == stop);
      sync_i = s;
      case (i)
        0: bus_i = a[3:0];
        1: bus_i = a[7:4];
        2: bus_i = a[11:8];
        3: bus_i = op[7:4];
        4: bus_i = op[3:0];
        default: bus_i = 4'(i * 5 + 3);
      endcase
      @(negedge clk);
      if (i == 2 && !s) exp_addr = a;
      if (i == 4 && !s) exp_op = op;
      chk(s ? "R1 restart" : "R1 step", 32'(phase_o), s ? 32'd0 : 32'((i + 1) % 8));
      chk(s ? "R6 addr strobe" : "R4 addr strobe", 32'(addr_vld_o), 32'(i == 2 && !s));
      chk(s ? "R6 op strobe" : "R4 op strobe", 32'(op_vld_o), 32'(i == 4 && !s));
      chk(i == 2 ? "R2 address" : "R5 address hold", 32'(addr_o), 32'(exp_addr));
      chk(i == 4 ? "R3 opcode" : "R5 opcode hold", 32'(opcode_o), 32'(exp_op));
    end
    sync_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    chk("R7 reset phase", 32'(phase_o), 32'd0);
    chk("R7 reset addr", 32'(addr_o), 32'd0);
    chk("R7 reset opcode", 32'(opcode_o), 32'd0);
    chk("R7 reset strobes", 32'({addr_vld_o, op_vld_o}), 32'd0);
    // no sync yet: address-like traffic must not strobe
    for (int i = 0; i < 12; i++) begin
      bus_i = 4'(i + 9);
      @(negedge clk);
      chk("R7 no strobe before sync", 32'({addr_vld_o, op_vld_o}), 32'd0);
      chk("R1 free count", 32'(phase_o), 32'((i + 1) % 8));
    end
    sync_i = 1'b1;
    @(negedge clk);
    sync_i = 1'b0;
    chk("R1 sync to phase 0", 32'(phase_o), 32'd0);

    // table walk; entries without sync bit continue by wrap (R8)
    foreach (VEC[v]) run_cyc(VEC[v][19:8], VEC[v][7:0], 7, VEC[v][20]);

    // directed aborts (R6): phase 1, at address commit, at opcode commit
    run_cyc(12'h3C3, 8'h99, 1, 1'b1);
    run_cyc(12'h6B6, 8'h77, 2, 1'b1);
    run_cyc(12'h421, 8'hE1, 7, 1'b1);
    run_cyc(12'hDEF, 8'h5A, 4, 1'b1);
    chk("R6 address kept after op abort", 32'(addr_o), 32'h0DEF);
    chk("R6 opcode kept", 32'(opcode_o), 32'hE1);
    run_cyc(12'h0F0, 8'h0F, 7, 1'b0);
    run_cyc(12'hB2D, 8'h83, 7, 1'b0);  // R8 wrap after abort recovery

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule